// File: doc/BRIEF.md
# Three-Stage Lane Stress Pattern Sequencer

This block is the pattern source for one lane of a receiver stress tester. Each clock it hands a 10-bit word to a downstream serializer. Bit 0 of each word is the first bit on the wire. The block plays three segments in a fixed order. The first is a clock-like frequency-lock word. The second is a short repeating symbol-lock group. The third is a PRBS 2^7-1 stream. The first two segments repeat until a break pulse moves the sequence on. The PRBS segment repeats for good, and only a restart pulse or a reset leaves it. A separate output drives a half-rate clock aggressor pattern, 1100 repeating, for the neighbouring lanes.

Bit errors can be forced onto the lane in two ways. A single-error pulse flips one outgoing bit. In counted mode an armed count n flips one bit in each of the next n PRBS periods, and no bits after that. Every output is registered. All inputs sampled at a clock edge act on the word loaded at that same edge. `seg_o` always names the segment of the word currently on `data_o`.

Top module: `lane_stress_sequencer`

## Requirements
- R1: While `rst_ni` is low, `data_o` and `aggr_o` are 0 and `seg_o` is 0.
- R2: `seg_o` codes are 0 for frequency lock, 1 for symbol lock and 2 for PRBS. A break moves 0 to 1 and 1 to 2, and the new segment's first word is loaded at that edge. A break while `seg_o` is 2 changes nothing.
- R3: A restart loads the frequency-lock segment from any segment and takes priority over a simultaneous break. It clears any armed counted-mode errors. The next PRBS entry begins again from the seed.
- R4: In segment 0 every word is 0x155. This includes the first word loaded after reset is released.
- R5: In segment 1 the words repeat 0x0FA, 0x305, 0x2CB, 0x134, beginning with 0x0FA on entry.
- R6: In segment 2, bit j of the w-th word since entry is b[10w+j]. Here b[k] = b[k-7] XOR b[k-6], and b[-7..-1] are all 1. This gives a 127-bit period.
- R7: An error pulse with no transition at that edge flips bit 0 of the word loaded at that edge.
- R8: An error pulse at an edge that restarts or performs a break is held instead. It flips bit 0 of the next word. A break while in segment 2 is not a transition.
- R9: A `burst_start_i` pulse arms the count `burst_n_i`. After that, for each of the next n PRBS periods, the bit at the period's first position (a stream index that is a multiple of 127) is flipped.
- R10: `aggr_o` is 0x333 at the first edge after reset and 0x0CC at the next. It then alternates every clock, and restart and break do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Return to the frequency-lock segment |
| break_i | input | 1 | Advance to the next segment |
| err_insert_i | input | 1 | Flip one outgoing bit |
| burst_start_i | input | 1 | Arm counted-mode errors |
| burst_n_i | input | BURST_W | Number of PRBS periods to corrupt |
| data_o | output | 10 | Lane word, bit 0 first on the wire |
| aggr_o | output | 10 | Half-rate clock aggressor word |
| seg_o | output | 2 | Segment of the word on data_o |

## Verification
A stimulus table first walks the two training segments. It mixes in error pulses that land on plain cycles, on breaks and on restarts, which separates immediate flips from held flips. Directed runs then compare a long PRBS stretch against a bench-side recurrence. Those runs test a break and an error pulse inside the PRBS segment, which must not be held. A counted run covers three periods, so the bits that must flip (stream bits 0, 127 and 254) are told apart from the fourth period start, which must stay clean. A restart in the middle of an armed burst shows that the count is cleared and the seed is reloaded.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int SYM_W = 10;
  localparam int SYM_LEN = 4;
  localparam logic [SYM_W-1:0] FREQ_WORD = 10'h155;

  typedef enum logic [1:0] {
    SEG_FREQ = 2'd0,
    SEG_SYM  = 2'd1,
    SEG_PRBS = 2'd2
  } seg_e;
endpackage

// File: rtl/lss_prbs_par.sv
module lss_prbs_par #(
  parameter int W = 10
) (
  input  logic [6:0]   state_i,
  output logic [W-1:0] word_o,
  output logic [6:0]   state_o
);
  logic [6:0] s;
  logic       nb;

  // x^7+x^6+1, W bits unrolled per clock
  always_comb begin
    s = state_i;
    nb = 1'b0;
    word_o = '0;
    for (int j = 0; j < W; j++) begin
      nb = s[6] ^ s[5];
      word_o[j] = nb;
      s = {s[5:0], nb};
    end
    state_o = s;
  end
endmodule

// File: rtl/lss_sym_table.sv
module lss_sym_table
  import lss_pkg::*;
(
  input  logic [$clog2(SYM_LEN)-1:0] idx_i,
  output logic [SYM_W-1:0]           word_o
);
  always_comb begin
    case (idx_i)
      2'd0:    word_o = 10'h0FA;
      2'd1:    word_o = 10'h305;
      2'd2:    word_o = 10'h2CB;
      default: word_o = 10'h134;
    endcase
  end
endmodule

// File: rtl/lss_aggr_gen.sv
module lss_aggr_gen #(
  parameter int W = 10,
  parameter int PER = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] aggr_o
);
  localparam int PH_W = $clog2(PER);

  logic [PH_W-1:0] ph_q;
  logic [W-1:0]    word;

  always_comb begin
    for (int j = 0; j < W; j++) begin
      word[j] = ((int'(ph_q) + j) % PER) < (PER / 2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      aggr_o <= '0;
    end else begin
      ph_q   <= PH_W'((int'(ph_q) + W) % PER);
      aggr_o <= word;
    end
  end
endmodule

// File: rtl/lss_err_ctrl.sv
module lss_err_ctrl #(
  parameter int W = 10,
  parameter int PERIOD = 127,
  parameter int BURST_W = 4,
  parameter int ERR_BIT = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               trans_i,
  input  logic               err_i,
  input  logic               in_prbs_i,
  input  logic               burst_start_i,
  input  logic [BURST_W-1:0] burst_n_i,
  output logic [W-1:0]       mask_o
);
  localparam int PH_W  = $clog2(PERIOD);
  localparam int POS_W = $clog2(W);

  logic [PH_W-1:0]    ph_q, ph_d;
  logic [BURST_W-1:0] cnt_q;
  logic               pend_q;
  logic               hit, fire, manual;
  logic [POS_W-1:0]   pos;

  // does a PRBS period begin inside the current word, and where
  always_comb begin
    hit = 1'b0;
    pos = '0;
    if (ph_q == '0) begin
      hit = 1'b1;
    end else if (int'(ph_q) + W > PERIOD) begin
      hit = 1'b1;
      pos = POS_W'(PERIOD - int'(ph_q));
    end
  end

  assign fire   = in_prbs_i && hit && (cnt_q != '0) && !burst_start_i;
  assign manual = (err_i || pend_q) && !trans_i;

  always_comb begin
    if (!in_prbs_i) ph_d = '0;
    else if (int'(ph_q) + W >= PERIOD) ph_d = PH_W'(int'(ph_q) + W - PERIOD);
    else ph_d = PH_W'(int'(ph_q) + W);
  end

  always_comb begin
    mask_o = '0;
    if (manual) mask_o[ERR_BIT] = 1'b1;
    if (fire) mask_o[pos] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= (err_i || pend_q) && trans_i;
      if (restart_i) cnt_q <= '0;
      else if (burst_start_i) cnt_q <= burst_n_i;
      else if (fire) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lane_stress_sequencer.sv
module lane_stress_sequencer
  import lss_pkg::*;
#(
  parameter int BURST_W = 4,
  parameter int ERR_BIT = 0,
  parameter logic [6:0] PRBS_SEED = 7'h7F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               break_i,
  input  logic               err_insert_i,
  input  logic               burst_start_i,
  input  logic [BURST_W-1:0] burst_n_i,
  output logic [SYM_W-1:0]   data_o,
  output logic [SYM_W-1:0]   aggr_o,
  output logic [1:0]         seg_o
);
  localparam int IDX_W = $clog2(SYM_LEN);
  localparam int PERIOD = 127;

  seg_e             seg_q, seg_d;
  logic             trans;
  logic [IDX_W-1:0] sym_idx_q;
  logic [6:0]       prbs_q, prbs_nxt;
  logic [SYM_W-1:0] sym_word, prbs_word, word, mask;

  assign trans = restart_i || (break_i && seg_q != SEG_PRBS);

  always_comb begin
    seg_d = seg_q;
    if (restart_i) seg_d = SEG_FREQ;
    else if (break_i) begin
      case (seg_q)
        SEG_FREQ: seg_d = SEG_SYM;
        SEG_SYM:  seg_d = SEG_PRBS;
        default:  seg_d = seg_q;
      endcase
    end
  end

  lss_sym_table u_sym (
    .idx_i (sym_idx_q),
    .word_o(sym_word)
  );

  lss_prbs_par #(.W(SYM_W)) u_prbs (
    .state_i(prbs_q),
    .word_o (prbs_word),
    .state_o(prbs_nxt)
  );

  lss_err_ctrl #(
    .W(SYM_W), .PERIOD(PERIOD), .BURST_W(BURST_W), .ERR_BIT(ERR_BIT)
  ) u_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart_i),
    .trans_i      (trans),
    .err_i        (err_insert_i),
    .in_prbs_i    (seg_d == SEG_PRBS),
    .burst_start_i(burst_start_i),
    .burst_n_i    (burst_n_i),
    .mask_o       (mask)
  );

  lss_aggr_gen #(.W(SYM_W), .PER(4)) u_aggr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .aggr_o(aggr_o)
  );

  always_comb begin
    case (seg_d)
      SEG_SYM:  word = sym_word;
      SEG_PRBS: word = prbs_word;
      default:  word = FREQ_WORD;
    endcase
  end

  // generator state rests at its start value outside its own segment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q     <= SEG_FREQ;
      sym_idx_q <= '0;
      prbs_q    <= PRBS_SEED;
      data_o    <= '0;
    end else begin
      seg_q     <= seg_d;
      sym_idx_q <= (seg_d == SEG_SYM) ? IDX_W'(int'(sym_idx_q) + 1) : '0;
      prbs_q    <= (seg_d == SEG_PRBS) ? prbs_nxt : PRBS_SEED;
      data_o    <= word ^ mask;
    end
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/lane_stress_sequencer_chk.sv
module lane_stress_sequencer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic       break_i,
  input logic       err_insert_i,
  input logic [9:0] data_o,
  input logic [9:0] aggr_o,
  input logic [1:0] seg_o
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else started_q <= 1'b1;
  end

  a_r2_break_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 2'd0 && break_i && !restart_i) |=> seg_o == 2'd1);

  a_r2_prbs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 2'd2 && !restart_i) |=> seg_o == 2'd2);

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> seg_o == 2'd0);

  a_r4_freq_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && seg_o == 2'd0) |-> (data_o == 10'h155 || data_o == 10'h154));

  a_r7_flip_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 2'd0 && err_insert_i && !restart_i && !break_i) |=> data_o == 10'h154);

  a_r10_alt_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aggr_o == 10'h333 |=> aggr_o == 10'h0CC);

  a_r10_alt_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aggr_o == 10'h0CC |=> aggr_o == 10'h333);
endmodule

bind lane_stress_sequencer lane_stress_sequencer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .break_i     (break_i),
  .err_insert_i(err_insert_i),
  .data_o      (data_o),
  .aggr_o      (aggr_o),
  .seg_o       (seg_o)
);

// File: tb/lane_stress_sequencer_test.sv
`timescale 1ns/1ps
module lane_stress_sequencer_test;
  localparam real CLK_NS = 20.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0, brk = 1'b0, err = 1'b0, bstart = 1'b0;
  logic [3:0] bn = '0;
  logic [9:0] data, aggr;
  logic [1:0] seg;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [9:0] exp_aggr;
  logic ref_bits [0:519];

  always #(CLK_NS / 2) clk = ~clk;

  lane_stress_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .break_i(brk),
    .err_insert_i(err), .burst_start_i(bstart), .burst_n_i(bn),
    .data_o(data), .aggr_o(aggr), .seg_o(seg)
  );

  // {restart, break, err, seg, data}
  localparam logic [14:0] VEC [0:11] = '{
    {3'b000, 2'd0, 10'h155},  // R4
    {3'b001, 2'd0, 10'h154},  // R7
    {3'b010, 2'd1, 10'h0FA},  // R2 R5
    {3'b000, 2'd1, 10'h305},
    {3'b001, 2'd1, 10'h2CA},  // R7 in symbol segment
    {3'b000, 2'd1, 10'h134},
    {3'b000, 2'd1, 10'h0FA},  // R5 wrap
    {3'b101, 2'd0, 10'h155},  // R3, R8 held
    {3'b000, 2'd0, 10'h154},  // R8 applied
    {3'b011, 2'd1, 10'h0FA},  // R8 held on break
    {3'b000, 2'd1, 10'h304},  // R8 applied
    {3'b000, 2'd1, 10'h2CB}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic b, input logic e,
                      input logic bs, input logic [3:0] n);
    @(negedge clk);
    restart = r; brk = b; err = e; bstart = bs; bn = n;
    @(posedge clk);
    #1;
    exp_aggr = (exp_aggr == 10'h333) ? 10'h0CC : 10'h333;
    chk("R10 aggressor", {22'd0, aggr}, {22'd0, exp_aggr});
  endtask

  function automatic logic [9:0] exp_prbs(input int w, input int n);
    logic [9:0] v;
    for (int j = 0; j < 10; j++) begin
      int a = 10 * w + j;
      v[j] = ref_bits[a + 7] ^ ((a % 127 == 0) && (a / 127 < n));
    end
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 7; i++) ref_bits[i] = 1'b1;
    for (int i = 0; i < 513; i++) ref_bits[i + 7] = ref_bits[i] ^ ref_bits[i + 1];

    repeat (3) @(posedge clk);
    #1;
    chk("R1 data", {22'd0, data}, 32'd0);
    chk("R1 aggr", {22'd0, aggr}, 32'd0);
    chk("R1 seg", {30'd0, seg}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    exp_aggr = 10'h333;
    chk("R4 first word", {22'd0, data}, 32'h155);
    chk("R10 first aggr", {22'd0, aggr}, 32'h333);

    for (int k = 0; k < 12; k++) begin
      tick(VEC[k][14], VEC[k][13], VEC[k][12], 1'b0, 4'd0);
      chk("R2/R5/R8 table seg", {30'd0, seg}, {30'd0, VEC[k][11:10]});
      chk("R4/R5/R7/R8 table data", {22'd0, data}, {22'd0, VEC[k][9:0]});
    end

    // R6 PRBS stretch past one period
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    chk("R2 enter prbs", {30'd0, seg}, 32'd2);
    chk("R6 word0", {22'd0, data}, {22'd0, exp_prbs(0, 0)});
    for (int w = 1; w < 20; w++) begin
      tick(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
      chk("R6 prbs word", {22'd0, data}, {22'd0, exp_prbs(w, 0)});
    end
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    chk("R2 break ignored seg", {30'd0, seg}, 32'd2);
    chk("R2 break ignored data", {22'd0, data}, {22'd0, exp_prbs(20, 0)});
    tick(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    chk("R7 prbs flip", {22'd0, data}, {22'd0, exp_prbs(21, 0) ^ 10'h001});
    tick(1'b0, 1'b1, 1'b1, 1'b0, 4'd0);
    chk("R8 no hold in prbs", {22'd0, data}, {22'd0, exp_prbs(22, 0) ^ 10'h001});
    tick(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    chk("R8 nothing deferred", {22'd0, data}, {22'd0, exp_prbs(23, 0)});

    tick(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    chk("R3 restart beats break seg", {30'd0, seg}, 32'd0);
    chk("R3 restart data", {22'd0, data}, 32'h155);

    // R9 counted mode, n=3
    tick(1'b0, 1'b0, 1'b0, 1'b1, 4'd3);
    chk("R9 arm in seg0", {22'd0, data}, 32'h155);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    chk("R9/R3 reseeded word0", {22'd0, data}, {22'd0, exp_prbs(0, 3)});
    for (int w = 1; w < 45; w++) begin
      tick(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
      chk("R9 counted word", {22'd0, data}, {22'd0, exp_prbs(w, 3)});
    end

    // R3 restart clears armed count
    tick(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 4'd5);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    chk("R9 n=5 word0", {22'd0, data}, {22'd0, exp_prbs(0, 5)});
    tick(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    chk("R3 restart from prbs", {30'd0, seg}, 32'd0);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    chk("R3 burst cleared word0", {22'd0, data}, {22'd0, exp_prbs(0, 0)});
    for (int w = 1; w < 14; w++) begin
      tick(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
      chk("R3 burst cleared", {22'd0, data}, {22'd0, exp_prbs(w, 0)});
    end
    tick(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule